// File: doc/BRIEF.md
# SAR Conversion Start and Tracking Sequencer

This block is the digital front end of a 10-bit successive-approximation converter. It chooses which event launches a conversion: a software write, an overflow from one of three timers, or a rising edge on an external start pin. It produces the SAR clock by dividing either the system clock or a slower low-power clock. It then runs an optional tracking phase and a ten-step binary search. The search drives a trial code to the analog side and reads back one comparator bit for each step.

While a conversion is in flight the block holds a busy flag high. When busy drops, the finished code is stored and a sticky completion flag is raised, which can also drive an interrupt request. A track-enable output tells the sampling circuit when to follow the input. In the default tracking mode it follows the input whenever no conversion is running. A low-power tracking mode instead inserts three SAR clocks of tracking after each start, or, when the external pin is the trigger, tracks only while that pin is low.

Top module: `adc_seq_top`

## Requirements
- R1: With `burstEn`=0 and divide value N on `clkDiv`, one SAR clock lasts N+1 system clocks, and a conversion in the default tracking mode keeps `busy` high for exactly 10*(N+1) system clocks.
- R2: With `burstEn`=1 the SAR clock counts synchronized rising edges of `lpClk`, one SAR clock per N+1 edges, so a conversion lasts about 10*(N+1) `lpClk` periods.
- R3: `startMode` selects the trigger: 000 software write (`swStartWr`), 001 timer 0 overflow, 010 timer 2, 011 timer 3, 100 external pin. Codes 101 to 111 start nothing, and a source that is not selected is ignored.
- R4: For timers 2 and 3, the low-byte overflow is the trigger when that timer's split bit (`t2Split`/`t3Split`) is 1 (8-bit mode). The high-byte overflow is the trigger when the split bit is 0 (16-bit mode).
- R5: `cnvPin` passes through two synchronizer flops before rising-edge detection. A conversion starts three clock edges after the pin rises. A pin held high never starts a second conversion.
- R6: `busy` rises at the clock edge that accepts a trigger and stays high through the whole conversion. A trigger that arrives while `busy` is high is ignored.
- R7: Bits are decided MSB first, one per SAR clock. The first trial code is 10'b1000000000. A comparator bit `cmpIn`=1 keeps the bit under trial and 0 clears it, so the result is the largest code not above the input.
- R8: At the edge where `busy` falls, `result` takes the new code and `doneFlag` becomes 1. `result` changes at no other time.
- R9: `doneFlag` stays set until a cycle with `flagClrWr`=1. A completion in the same cycle as a clear leaves the flag set. `irq` equals `doneFlag` AND `intEn`.
- R10: With `lowPowerTrack`=0, `trackEn` is 1 whenever `busy` is 0 and 0 for every cycle of a conversion.
- R11: With `lowPowerTrack`=1 and a start mode other than 100, `trackEn` is 0 while idle. After a start, `trackEn` is 1 for 3*(N+1) cycles and 0 for the following 10*(N+1) cycles, all with `busy` high.
- R12: With `lowPowerTrack`=1 and start mode 100, `trackEn` follows the synchronized pin while idle (1 when low). Conversion starts on the rising edge with no added tracking clocks, taking 10*(N+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| burstEn | input | 1 | 1: SAR clock from low-power clock; 0: from system clock |
| clkDiv | input | 5 | Divide value N; SAR period is N+1 source clocks |
| lpClk | input | 1 | Low-power oscillator, asynchronous to clk |
| startMode | input | 3 | Trigger source select |
| lowPowerTrack | input | 1 | Low-power tracking mode enable |
| swStartWr | input | 1 | Software start write strobe |
| t0Ovf | input | 1 | Timer 0 overflow pulse |
| t2LowOvf | input | 1 | Timer 2 low-byte overflow pulse |
| t2HighOvf | input | 1 | Timer 2 high-byte overflow pulse |
| t2Split | input | 1 | Timer 2 in 8-bit mode |
| t3LowOvf | input | 1 | Timer 3 low-byte overflow pulse |
| t3HighOvf | input | 1 | Timer 3 high-byte overflow pulse |
| t3Split | input | 1 | Timer 3 in 8-bit mode |
| cnvPin | input | 1 | External convert-start pin, asynchronous |
| cmpIn | input | 1 | Comparator decision: input at or above trial code |
| flagClrWr | input | 1 | Software write of 0 to the completion flag |
| intEn | input | 1 | Interrupt enable |
| busy | output | 1 | Conversion in progress |
| trackEn | output | 1 | Track-and-hold follows the input |
| sarCode | output | 10 | Trial code to the comparison DAC |
| result | output | 10 | Last completed conversion code |
| doneFlag | output | 1 | Sticky conversion-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The binary search is run with a bench comparator model that compares an analog value with the live trial code. The values used are mid-scale odd patterns, all-zeros and all-ones. This separates a wrong bit order or an inverted keep/clear decision from correct behaviour, and exposes any off-by-one at the code extremes. Conversion length is counted in cycles for several divide values and for both clock sources, which separates the N+1 divide rule from an N rule and the system clock from the low-power clock. Every trigger source is tried both selected and unselected, with the timer split bit in both settings, along with the unused mode codes. The pin trigger is checked for exact synchronizer latency and for the absence of a retrigger while the pin is held high. Track-enable is traced cycle by cycle in all three tracking situations.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Width of the bit pointer carried in the strobe bundle (resolutions up to 32 bits)
  localparam int unsigned IDX_W = 5;

  typedef enum logic [2:0] {
    SRC_SOFT = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_TMR2 = 3'd2,
    SRC_TMR3 = 3'd3,
    SRC_PIN  = 3'd4
  } startSrc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seqState_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic             startConv;  // load MSB trial code
    logic             decide;     // resolve bit at bitIdx this cycle
    logic             lastBit;    // bitIdx is the LSB
    logic [IDX_W-1:0] bitIdx;     // bit under trial
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] startMode,
  input  logic       swStartWr,
  input  logic       t0Ovf,
  input  logic       t2LowOvf,
  input  logic       t2HighOvf,
  input  logic       t2Split,
  input  logic       t3LowOvf,
  input  logic       t3HighOvf,
  input  logic       t3Split,
  input  logic       cnvPin,
  output logic       trigPulse,
  output logic       pinLevel
);

  logic [SYNC_STAGES-1:0] pinSync;
  logic                   pinPrev;
  logic                   pinRise;
  logic                   t2Trig;
  logic                   t3Trig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync <= '0;
      pinPrev <= 1'b0;
    end else begin
      pinSync <= {pinSync[SYNC_STAGES-2:0], cnvPin};
      pinPrev <= pinSync[SYNC_STAGES-1];
    end
  end

  assign pinLevel = pinSync[SYNC_STAGES-1];
  assign pinRise  = pinLevel & ~pinPrev;

  // 8-bit (split) timers overflow from the low byte, 16-bit timers from the high byte
  assign t2Trig = t2Split ? t2LowOvf : t2HighOvf;
  assign t3Trig = t3Split ? t3LowOvf : t3HighOvf;

  always_comb begin
    case (startMode)
      SRC_SOFT: trigPulse = swStartWr;
      SRC_TMR0: trigPulse = t0Ovf;
      SRC_TMR2: trigPulse = t2Trig;
      SRC_TMR3: trigPulse = t3Trig;
      SRC_PIN:  trigPulse = pinRise;
      default:  trigPulse = 1'b0;
    endcase
  end

endmodule

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned LP_SYNC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstEn,
  input  logic [DIV_W-1:0] divN,
  input  logic             lpClk,
  input  logic             restart,
  output logic             sarTick
);

  logic [LP_SYNC-1:0] lpSync;
  logic               lpPrev;
  logic               lpRise;
  logic               srcPulse;
  logic [DIV_W-1:0]   divCnt;
  logic               atTop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lpSync <= '0;
      lpPrev <= 1'b0;
    end else begin
      lpSync <= {lpSync[LP_SYNC-2:0], lpClk};
      lpPrev <= lpSync[LP_SYNC-1];
    end
  end

  assign lpRise   = lpSync[LP_SYNC-1] & ~lpPrev;
  assign srcPulse = burstEn ? lpRise : 1'b1;
  assign atTop    = (divCnt >= divN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (restart) begin
      divCnt <= '0;
    end else if (srcPulse) begin
      divCnt <= atTop ? '0 : divCnt + 1'b1;
    end
  end

  assign sarTick = srcPulse & atTop & ~restart;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W      = 10,
  parameter int unsigned TRACK_CLKS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigPulse,
  input  logic       sarTick,
  input  logic [2:0] startMode,
  input  logic       lowPowerTrack,
  input  logic       pinLevel,
  output logic       busy,
  output logic       trackEn,
  output logic       divRestart,
  output seqStrobe_t strb
);

  localparam int unsigned TRK_W = $clog2(TRACK_CLKS + 1);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);
  localparam logic [TRK_W-1:0] TRK_LAST = TRK_W'(TRACK_CLKS - 1);

  seqState_e        state;
  logic [IDX_W-1:0] bitCnt;
  logic [TRK_W-1:0] trkCnt;
  logic             pinMode;
  logic             goTrack;
  logic             trkDone;

  assign pinMode = (startMode == SRC_PIN);
  assign goTrack = lowPowerTrack & ~pinMode;
  assign trkDone = (trkCnt == TRK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      trkCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trigPulse) begin
            if (goTrack) begin
              state  <= ST_TRACK;
              trkCnt <= '0;
            end else begin
              state  <= ST_CONV;
              bitCnt <= TOP_IDX;
            end
          end
        end
        ST_TRACK: begin
          if (sarTick) begin
            if (trkDone) begin
              state  <= ST_CONV;
              bitCnt <= TOP_IDX;
            end else begin
              trkCnt <= trkCnt + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (sarTick) begin
            if (bitCnt == '0) begin
              state <= ST_IDLE;
            end else begin
              bitCnt <= bitCnt - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign divRestart = (state == ST_IDLE) & trigPulse;

  always_comb begin
    strb.startConv = ((state == ST_IDLE) & trigPulse & ~goTrack) |
                     ((state == ST_TRACK) & sarTick & trkDone);
    strb.decide    = (state == ST_CONV) & sarTick;
    strb.lastBit   = (bitCnt == '0);
    strb.bitIdx    = bitCnt;
  end

  always_comb begin
    case (state)
      ST_IDLE:  trackEn = lowPowerTrack ? (pinMode & ~pinLevel) : 1'b1;
      ST_TRACK: trackEn = 1'b1;
      default:  trackEn = 1'b0;
    endcase
  end

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             cmpIn,
  input  logic             flagClrWr,
  input  logic             intEn,
  output logic [RES_W-1:0] sarCode,
  output logic [RES_W-1:0] result,
  output logic             doneFlag,
  output logic             irq
);

  localparam logic [RES_W-1:0] ONE_LSB   = {{(RES_W-1){1'b0}}, 1'b1};
  localparam logic [RES_W-1:0] MSB_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] curMask;
  logic [RES_W-1:0] nextCode;
  logic             finishStb;

  assign curMask   = ONE_LSB << strb.bitIdx;
  assign finishStb = strb.decide & strb.lastBit;

  // Keep or drop the bit under trial, then try the next lower one
  always_comb begin
    nextCode = sarCode;
    if (!cmpIn) begin
      nextCode = nextCode & ~curMask;
    end
    nextCode = nextCode | (curMask >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarCode <= '0;
      result  <= '0;
    end else begin
      if (strb.startConv) begin
        sarCode <= MSB_TRIAL;
      end else if (strb.decide) begin
        sarCode <= nextCode;
      end
      if (finishStb) begin
        result <= nextCode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
    end else if (finishStb) begin
      doneFlag <= 1'b1;
    end else if (flagClrWr) begin
      doneFlag <= 1'b0;
    end
  end

  assign irq = doneFlag & intEn;

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W      = 10,
  parameter int unsigned DIV_W      = 5,
  parameter int unsigned TRACK_CLKS = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstEn,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             lpClk,
  input  logic [2:0]       startMode,
  input  logic             lowPowerTrack,
  input  logic             swStartWr,
  input  logic             t0Ovf,
  input  logic             t2LowOvf,
  input  logic             t2HighOvf,
  input  logic             t2Split,
  input  logic             t3LowOvf,
  input  logic             t3HighOvf,
  input  logic             t3Split,
  input  logic             cnvPin,
  input  logic             cmpIn,
  input  logic             flagClrWr,
  input  logic             intEn,
  output logic             busy,
  output logic             trackEn,
  output logic [RES_W-1:0] sarCode,
  output logic [RES_W-1:0] result,
  output logic             doneFlag,
  output logic             irq
);

  logic       trigPulse;
  logic       pinLevel;
  logic       sarTick;
  logic       divRestart;
  seqStrobe_t strb;

  adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rstN      (rstN),
    .startMode (startMode),
    .swStartWr (swStartWr),
    .t0Ovf     (t0Ovf),
    .t2LowOvf  (t2LowOvf),
    .t2HighOvf (t2HighOvf),
    .t2Split   (t2Split),
    .t3LowOvf  (t3LowOvf),
    .t3HighOvf (t3HighOvf),
    .t3Split   (t3Split),
    .cnvPin    (cnvPin),
    .trigPulse (trigPulse),
    .pinLevel  (pinLevel)
  );

  adc_seq_clkdiv #(.DIV_W(DIV_W), .LP_SYNC(SYNC_STAGES)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .burstEn (burstEn),
    .divN    (clkDiv),
    .lpClk   (lpClk),
    .restart (divRestart),
    .sarTick (sarTick)
  );

  adc_seq_ctrl #(.RES_W(RES_W), .TRACK_CLKS(TRACK_CLKS)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .trigPulse     (trigPulse),
    .sarTick       (sarTick),
    .startMode     (startMode),
    .lowPowerTrack (lowPowerTrack),
    .pinLevel      (pinLevel),
    .busy          (busy),
    .trackEn       (trackEn),
    .divRestart    (divRestart),
    .strb          (strb)
  );

  adc_seq_dpath #(.RES_W(RES_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpIn     (cmpIn),
    .flagClrWr (flagClrWr),
    .intEn     (intEn),
    .sarCode   (sarCode),
    .result    (result),
    .doneFlag  (doneFlag),
    .irq       (irq)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             doneFlag,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] sarCode,
  input logic             flagClrWr,
  input logic             trigPulse,
  input logic             startConv,
  input logic             decide,
  input logic             lastBit
);

  localparam logic [RES_W-1:0] MSB_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

  // R8: completion flag is up in the cycle busy drops
  p_fall_sets_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);

  // R8: the result register moves only at a completion
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(busy) |-> $stable(result));

  // R6: busy only rises after an accepted trigger
  p_rise_needs_trig_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trigPulse));

  // R6: a trigger while busy does not end or restart the conversion
  p_busy_ignores_trig_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trigPulse && !(decide && lastBit)) |=> busy);

  // R9: a clear with no completion in the same cycle drops the flag
  p_clear_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flagClrWr && !(decide && lastBit)) |=> !doneFlag);

  // R7: the search opens with only the MSB on trial
  p_msb_trial_r7: assert property (@(posedge clk) disable iff (!rstN)
    startConv |=> (sarCode == MSB_TRIAL));

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .doneFlag  (doneFlag),
  .result    (result),
  .sarCode   (sarCode),
  .flagClrWr (flagClrWr),
  .trigPulse (trigPulse),
  .startConv (strb.startConv),
  .decide    (strb.decide),
  .lastBit   (strb.lastBit)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;

  localparam int RES_W = 10;
  localparam int DIV_W = 5;

  logic             clk;
  logic             rstN;
  logic             burstEn;
  logic [DIV_W-1:0] clkDiv;
  logic             lpClk;
  logic             lpRun;
  logic [2:0]       startMode;
  logic             lowPowerTrack;
  logic             swStartWr, t0Ovf, t2LowOvf, t2HighOvf, t2Split;
  logic             t3LowOvf, t3HighOvf, t3Split, cnvPin;
  logic             cmpIn, flagClrWr, intEn;
  logic             busy, trackEn, doneFlag, irq;
  logic [RES_W-1:0] sarCode, result;
  logic [RES_W-1:0] vin;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  // Comparator model: input at or above trial code
  assign cmpIn = (vin >= sarCode);

  adc_seq_top u_dut (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .clkDiv(clkDiv), .lpClk(lpClk),
    .startMode(startMode), .lowPowerTrack(lowPowerTrack), .swStartWr(swStartWr),
    .t0Ovf(t0Ovf), .t2LowOvf(t2LowOvf), .t2HighOvf(t2HighOvf), .t2Split(t2Split),
    .t3LowOvf(t3LowOvf), .t3HighOvf(t3HighOvf), .t3Split(t3Split), .cnvPin(cnvPin),
    .cmpIn(cmpIn), .flagClrWr(flagClrWr), .intEn(intEn), .busy(busy),
    .trackEn(trackEn), .sarCode(sarCode), .result(result), .doneFlag(doneFlag),
    .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    lpClk = 1'b0;
    forever begin
      #40;
      if (lpRun) lpClk = ~lpClk;
      else lpClk = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pulse one trigger input for one cycle: 0 sw, 1 t0, 2 t2 low, 3 t2 high, 4 t3 low, 5 t3 high
  task automatic fire(input int src);
    case (src)
      0: swStartWr = 1'b1;
      1: t0Ovf     = 1'b1;
      2: t2LowOvf  = 1'b1;
      3: t2HighOvf = 1'b1;
      4: t3LowOvf  = 1'b1;
      default: t3HighOvf = 1'b1;
    endcase
    @(negedge clk);
    swStartWr = 1'b0; t0Ovf = 1'b0; t2LowOvf = 1'b0;
    t2HighOvf = 1'b0; t3LowOvf = 1'b0; t3HighOvf = 1'b0;
  endtask

  // Count busy cycles from the current sample; also count those with trackEn high
  task automatic measure(output int len, output int trk);
    len = 0;
    trk = 0;
    for (int g = 0; g < 5000 && busy; g++) begin
      len++;
      if (trackEn) trk++;
      @(negedge clk);
    end
  endtask

  task automatic clear_flag();
    flagClrWr = 1'b1;
    @(negedge clk);
    flagClrWr = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 busy after reset", busy, 0);
    check("R9 flag after reset", doneFlag, 0);
    check("R9 irq after reset", irq, 0);
    check("R8 result after reset", result, 0);
    check("R10 idle tracking default", trackEn, 1);
  endtask

  // Software conversion in default tracking mode
  task automatic t_soft_conv(input int n, input int v);
    int len, trk;
    startMode = 3'd0; clkDiv = DIV_W'(n); vin = RES_W'(v);
    fire(0);
    check("R6 busy after sw start", busy, 1);
    check("R7 first trial code", sarCode, 512);
    measure(len, trk);
    check("R1 conversion length", len, 10 * (n + 1));
    check("R10 no tracking while busy", trk, 0);
    check("R8 flag at completion", doneFlag, 1);
    check("R7 result code", result, v);
    check("R10 tracking resumes", trackEn, 1);
    clear_flag();
  endtask

  task automatic t_busy_ignore();
    int len, trk;
    startMode = 3'd0; clkDiv = 5'd1; vin = 10'd300;
    fire(0);
    step(5);
    fire(0);
    step(3);
    vin = 10'd300;
    measure(len, trk);
    check("R6 retrigger ignored length", len + 9, 20);
    step(3);
    check("R6 no queued start", busy, 0);
    check("R7 result with retrigger", result, 300);
    clear_flag();
  endtask

  task automatic t_flag_irq();
    int len, trk;
    startMode = 3'd0; clkDiv = 5'd0; vin = 10'd77; intEn = 1'b0;
    fire(0);
    measure(len, trk);
    check("R9 irq masked", irq, 0);
    intEn = 1'b1;
    step(1);
    check("R9 irq enabled", irq, 1);
    step(4);
    check("R9 flag sticky", doneFlag, 1);
    clear_flag();
    check("R9 flag cleared", doneFlag, 0);
    check("R9 irq cleared", irq, 0);
    // clear held through completion: set wins
    fire(0);
    flagClrWr = 1'b1;
    measure(len, trk);
    check("R9 set beats clear", doneFlag, 1);
    flagClrWr = 1'b0;
    step(1);
    clear_flag();
    intEn = 1'b0;
  endtask

  task automatic t_timers();
    int len, trk;
    clkDiv = 5'd0; vin = 10'd600;
    startMode = 3'd1;
    fire(0); step(3);
    check("R3 sw ignored in timer0 mode", busy, 0);
    fire(1);
    check("R3 timer0 start", busy, 1);
    measure(len, trk);
    check("R7 timer0 result", result, 600);
    clear_flag();
    startMode = 3'd2; t2Split = 1'b1;
    fire(3); step(3);
    check("R4 t2 8-bit ignores high byte", busy, 0);
    fire(2);
    check("R4 t2 8-bit low byte starts", busy, 1);
    measure(len, trk);
    clear_flag();
    t2Split = 1'b0;
    fire(2); step(3);
    check("R4 t2 16-bit ignores low byte", busy, 0);
    fire(3);
    check("R4 t2 16-bit high byte starts", busy, 1);
    measure(len, trk);
    clear_flag();
    startMode = 3'd3; t3Split = 1'b1;
    fire(5); step(3);
    check("R4 t3 8-bit ignores high byte", busy, 0);
    fire(4);
    check("R4 t3 8-bit low byte starts", busy, 1);
    measure(len, trk);
    clear_flag();
    t3Split = 1'b0;
    fire(1); step(3);
    check("R3 t0 ignored in timer3 mode", busy, 0);
    fire(5);
    check("R4 t3 16-bit high byte starts", busy, 1);
    measure(len, trk);
    clear_flag();
  endtask

  task automatic t_bad_modes();
    for (int m = 5; m < 8; m++) begin
      startMode = 3'(m);
      t2Split = m[0]; t3Split = m[1];
      for (int s = 0; s < 6; s++) fire(s);
      cnvPin = 1'b1; step(5); cnvPin = 1'b0; step(5);
      check("R3 unused mode starts nothing", busy, 0);
      check("R3 unused mode leaves flag", doneFlag, 0);
    end
  endtask

  task automatic t_pin();
    int len, trk;
    startMode = 3'd4; clkDiv = 5'd0; vin = 10'd1023;
    step(4);
    cnvPin = 1'b1;
    step(2);
    check("R5 not started before sync", busy, 0);
    step(1);
    check("R5 started three edges after rise", busy, 1);
    measure(len, trk);
    check("R1 pin conversion length", len, 10);
    check("R7 full-scale result", result, 1023);
    clear_flag();
    step(20);
    check("R5 held pin no retrigger", busy, 0);
    cnvPin = 1'b0; vin = 10'd0;
    step(5);
    cnvPin = 1'b1;
    step(3);
    check("R5 second rise starts", busy, 1);
    measure(len, trk);
    check("R7 zero result", result, 0);
    cnvPin = 1'b0;
    clear_flag();
  endtask

  task automatic t_lp_soft();
    int len, trk;
    lowPowerTrack = 1'b1; startMode = 3'd0; clkDiv = 5'd1; vin = 10'd421;
    step(2);
    check("R11 idle not tracking", trackEn, 0);
    fire(0);
    check("R11 tracking at start", trackEn, 1);
    measure(len, trk);
    check("R11 track cycles", trk, 6);
    check("R11 total busy", len, 26);
    check("R11 result", result, 421);
    clear_flag();
    lowPowerTrack = 1'b0;
  endtask

  task automatic t_lp_pin();
    int len, trk;
    lowPowerTrack = 1'b1; startMode = 3'd4; clkDiv = 5'd2; vin = 10'd5;
    cnvPin = 1'b0;
    step(4);
    check("R12 tracks while pin low", trackEn, 1);
    cnvPin = 1'b1;
    step(2);
    check("R12 tracking stops on high pin", trackEn, 0);
    check("R12 not yet busy", busy, 0);
    step(1);
    check("R12 busy on rise", busy, 1);
    measure(len, trk);
    check("R12 no extra track clocks", len, 30);
    check("R12 no tracking in conversion", trk, 0);
    check("R12 result", result, 5);
    cnvPin = 1'b0;
    clear_flag();
    lowPowerTrack = 1'b0;
  endtask

  task automatic t_burst();
    int len, trk;
    burstEn = 1'b1; lpRun = 1'b1; clkDiv = 5'd1; startMode = 3'd0; vin = 10'd819;
    step(30);
    fire(0);
    measure(len, trk);
    check("R2 burst length in lp periods", int'(len >= 145 && len <= 175), 1);
    check("R2 burst result", result, 819);
    clear_flag();
    burstEn = 1'b0; lpRun = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; burstEn = 1'b0; clkDiv = '0; lpRun = 1'b0;
    startMode = 3'd0; lowPowerTrack = 1'b0; swStartWr = 1'b0; t0Ovf = 1'b0;
    t2LowOvf = 1'b0; t2HighOvf = 1'b0; t2Split = 1'b0; t3LowOvf = 1'b0;
    t3HighOvf = 1'b0; t3Split = 1'b0; cnvPin = 1'b0; flagClrWr = 1'b0;
    intEn = 1'b0; vin = '0;
    step(4);
    rstN = 1'b1;
    step(2);
    t_reset();
    t_soft_conv(0, 677);
    t_soft_conv(3, 0);
    t_soft_conv(1, 1023);
    t_busy_ignore();
    t_flag_irq();
    t_timers();
    t_bad_modes();
    t_pin();
    t_lp_soft();
    t_lp_pin();
    t_burst();
    finished = 1;
    summary();
    $finish;
  end

endmodule